// File: doc/BRIEF.md
# Scanline Interrupt Counter with Filtered Address-Line Edges

This block counts scanlines by watching bit 12 of the video address bus. A rising edge on that bit counts as one scanline only if the bit stayed low for a minimum number of CPU cycles just before it. The CPU-cycle tick input measures that low time. The filter stops short toggles from counting as extra scanlines.

The counter is eight bits wide and loads from a latch. When a counted edge leaves the counter at zero and interrupts are enabled, the block raises a level interrupt. The interrupt stays asserted until software disables interrupts. The CPU sets the block up through a write port that takes a 16-bit address and a data byte. Four registers sit in the upper half of the address space: set the latch, request a reload, disable the interrupt, and enable it.

Top module: `scanIrqTop`

## Requirements
- R1: After reset the interrupt output is low, the counter and latch hold 0, no reload is pending and interrupts are disabled.
- R2: A write whose address has bit 15 = 1, bits 14:13 = 2'b10 and bit 0 = 0 stores the data byte in the reload latch.
- R3: A write whose address has bit 15 = 1, bits 14:13 = 2'b10 and bit 0 = 1 makes the next counted edge load the counter from the latch, even if the counter is not zero.
- R4: On a counted edge with no reload pending, a zero counter is loaded from the latch and a nonzero counter decrements by one.
- R5: If the counter value after a counted edge is zero and interrupts are enabled, the interrupt output goes high one clock later. It stays high through later edges.
- R6: A write with address bit 15 = 1, bits 14:13 = 2'b11 and bit 0 = 0 disables interrupts and drops the interrupt output in the next cycle.
- R7: A write with address bit 15 = 1, bits 14:13 = 2'b11 and bit 0 = 1 enables interrupts.
- R8: A 0-to-1 change of video address bit 12 is counted only if that bit was low for at least LOW_MIN CPU ticks beforehand (default 3). An edge after fewer ticks does not change the counter.
- R9: Writes with address bit 15 = 0 or bits 14:13 = 2'b0x change no state.
- R10: While interrupts are disabled, the counter reaching zero does not raise the interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | CPU register write strobe, one clock per write |
| regAddr | input | 16 | CPU write address |
| regData | input | 8 | CPU write data |
| vidAddr | input | 14 | Video address bus; bit 12 is watched |
| cpuTick | input | 1 | One-clock pulse per CPU cycle |
| irq | output | 1 | Level interrupt request, active high |

## Verification
The assertions assume each CPU write lasts one clock. They also assume bit 12 of the video address changes at most once per clock, so that one clock of history shows a rising edge. They expect a disable write and a counted edge not to fall in the same clock, because the disable write wins there. The stimulus drives every input on the falling clock edge and holds each write for a single cycle. It separates register writes from address-line transitions by idle cycles, so no write meets an edge in the same clock.

// File: rtl/scanIrqPkg.sv
package scanIrqPkg;
  typedef struct packed {
    logic latchWr;
    logic reloadReq;
    logic irqOff;
    logic irqOn;
    logic edgeHit;
  } ctrlStrobes_t;
endpackage

// File: rtl/scanIrqCtrl.sv
module scanIrqCtrl
  import scanIrqPkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int VADDR_W = 14,
  parameter int A12_BIT = 12,
  parameter int LOW_MIN = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [VADDR_W-1:0] vidAddr,
  input  logic               cpuTick,
  output ctrlStrobes_t       strobes
);
  localparam int LW = $clog2(LOW_MIN + 1) < 1 ? 1 : $clog2(LOW_MIN + 1);
  localparam logic [LW-1:0] LOW_SAT = LW'(LOW_MIN);

  logic          a12Now;
  logic          a12Q;
  logic [LW-1:0] lowCnt;
  logic          upperHit;
  logic [1:0]    regionSel;
  logic          oddSel;

  assign a12Now    = vidAddr[A12_BIT];
  assign upperHit  = regWe && regAddr[ADDR_W-1];
  assign regionSel = regAddr[ADDR_W-2:ADDR_W-3];
  assign oddSel    = regAddr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a12Q   <= 1'b1;
      lowCnt <= '0;
    end else begin
      a12Q <= a12Now;
      if (a12Now)
        lowCnt <= '0;
      else if (cpuTick && lowCnt < LOW_SAT)
        lowCnt <= lowCnt + 1'b1;
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.latchWr   = upperHit && regionSel == 2'b10 && !oddSel;
    strobes.reloadReq = upperHit && regionSel == 2'b10 && oddSel;
    strobes.irqOff    = upperHit && regionSel == 2'b11 && !oddSel;
    strobes.irqOn     = upperHit && regionSel == 2'b11 && oddSel;
    strobes.edgeHit   = a12Now && !a12Q && lowCnt >= LOW_SAT;
  end

  // R8: a counted edge leaves the line high in the following cycle
  assert_edge_then_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.edgeHit |=> a12Q);
  // R8: a counted edge never comes right after a high sample
  assert_edge_after_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(a12Q) && a12Q |-> !strobes.edgeHit);
  // R9: at most one register strobe per cycle
  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.latchWr, strobes.reloadReq, strobes.irqOff, strobes.irqOn}));
endmodule

// File: rtl/scanIrqDatapath.sv
module scanIrqDatapath
  import scanIrqPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     strobes,
  input  logic [CNT_W-1:0] wrData,
  output logic             irqPend
);
  logic [CNT_W-1:0] latchVal;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic             reloadPend;
  logic             irqEn;

  always_comb begin
    cntNext = cnt;
    if (strobes.edgeHit) begin
      if (cnt == '0 || reloadPend)
        cntNext = latchVal;
      else
        cntNext = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latchVal   <= '0;
      cnt        <= '0;
      reloadPend <= 1'b0;
      irqEn      <= 1'b0;
      irqPend    <= 1'b0;
    end else begin
      cnt <= cntNext;
      if (strobes.latchWr) latchVal <= wrData;
      if (strobes.reloadReq)    reloadPend <= 1'b1;
      else if (strobes.edgeHit) reloadPend <= 1'b0;
      if (strobes.irqOff) begin
        irqEn   <= 1'b0;
        irqPend <= 1'b0;
      end else begin
        if (strobes.irqOn) irqEn <= 1'b1;
        if (strobes.edgeHit && cntNext == '0 && irqEn) irqPend <= 1'b1;
      end
    end
  end

  // R4: counter only moves on a counted edge
  assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.edgeHit |=> $stable(cnt));
  // R6: disable write clears the interrupt in the next cycle
  assert_off_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.irqOff |=> !irqPend);
  // R10: a pending interrupt implies interrupts are enabled
  assert_pend_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irqPend |-> irqEn);
  // R5: interrupt rises only after a counted edge, with a zero counter
  assert_rise_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqPend) |-> $past(strobes.edgeHit) && cnt == '0);
endmodule

// File: rtl/scanIrqTop.sv
module scanIrqTop
  import scanIrqPkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int VADDR_W = 14,
  parameter int LOW_MIN = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regData,
  input  logic [VADDR_W-1:0] vidAddr,
  input  logic               cpuTick,
  output logic               irq
);
  localparam int A12_BIT = 12;

  ctrlStrobes_t strobes;

  scanIrqCtrl #(
    .ADDR_W(ADDR_W), .VADDR_W(VADDR_W), .A12_BIT(A12_BIT), .LOW_MIN(LOW_MIN)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr),
    .vidAddr(vidAddr), .cpuTick(cpuTick), .strobes(strobes)
  );

  scanIrqDatapath #(.CNT_W(DATA_W)) uDp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrData(regData), .irqPend(irq)
  );

  // R1: interrupt is low in the first cycle after reset
  assert_reset_low_R1: assert property (@(posedge clk)
    !$past(rst_n) |-> !irq);
endmodule

// File: tb/tb_scanIrqTop.sv
module tb_scanIrqTop;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // latch, edges, low ticks, expected irq
  localparam int VEC [NVEC][4] = '{
    '{1, 2, 3, 1}, '{1, 1, 3, 0}, '{3, 4, 3, 1}, '{3, 3, 3, 0},
    '{1, 2, 2, 0}, '{0, 1, 4, 1}, '{2, 3, 5, 1}
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic        regWe = 0;
  logic [15:0] regAddr = 0;
  logic [7:0]  regData = 0;
  logic [13:0] vidAddr = 14'h1000;
  logic        cpuTick = 0;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  scanIrqTop dut (.clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr),
    .regData(regData), .vidAddr(vidAddr), .cpuTick(cpuTick), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic exp);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq=%0b expected %0b", req, irq, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1; regAddr = a; regData = d;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic scanEdge(input int ticks);
    @(negedge clk);
    vidAddr = 14'h0FFF;
    for (int i = 0; i < ticks; i++) begin
      cpuTick = 1;
      @(negedge clk);
    end
    cpuTick = 0;
    @(negedge clk);
    vidAddr = 14'h1000;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic arm(input logic [7:0] lat);
    wr(16'hE000, 0);
    wr(16'hC000, lat);
    wr(16'hC001, 0);
    wr(16'hE001, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", 0);
    // R1: counter 0 at reset, latch 0 -> first edge reloads 0, so irq once enabled
    wr(16'hE001, 0);
    scanEdge(3);
    check("R1", 1);

    // vector table: R2 R3 R4 R5 R8
    for (int v = 0; v < NVEC; v++) begin
      arm(8'(VEC[v][0]));
      for (int e = 0; e < VEC[v][1]; e++) scanEdge(VEC[v][2]);
      check($sformatf("R4/R5/R8 vec%0d", v), 1'(VEC[v][3]));
    end

    // R5: level held through later edges
    arm(1);
    scanEdge(3); scanEdge(3);
    scanEdge(3);
    check("R5", 1);
    // R6: disable clears
    wr(16'hE000, 0);
    check("R6", 0);

    // R10: disabled, zero reached, no irq
    wr(16'hC000, 1); wr(16'hC001, 0);
    scanEdge(3); scanEdge(3);
    check("R10", 0);
    // R7: enable then reach zero
    wr(16'hE001, 0);
    scanEdge(3); scanEdge(3);
    check("R7", 1);

    // R9: ignored writes do not change latch
    arm(3);
    wr(16'h8000, 0); wr(16'hA001, 0); wr(16'h4000, 0); wr(16'h6001, 0);
    for (int e = 0; e < 3; e++) scanEdge(3);
    check("R9", 0);
    scanEdge(3);
    check("R9", 1);

    // R3: reload request mid-count
    arm(3);
    scanEdge(3); scanEdge(3);
    wr(16'hC001, 0);
    scanEdge(3); scanEdge(3); scanEdge(3);
    check("R3", 0);
    scanEdge(3);
    check("R3", 1);

    // R8: zero-tick low interval is filtered
    arm(1);
    scanEdge(3);
    scanEdge(0);
    check("R8", 0);
    scanEdge(3);
    check("R8", 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule